// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block records DRAM ECC failures and a few other memory-controller fault events, and exposes them to software through a small register set reached by byte offset. An ECC checker delivers one-cycle pulses for correctable and uncorrectable errors, together with the 33-bit failing address, the channel that carried the access and the 8-bit syndrome. Refresh-timeout, locked-access-to-non-DRAM and thermal events arrive as separate pulses.

Each event sets a sticky flag in a 16-bit status register. Software clears a flag by writing 1 to its position. The first correctable error is captured with its address, channel and syndrome. An uncorrectable error takes over the capture registers even when a correctable error is already held, so the more severe event is the one recorded. A 16-bit command register selects which events raise a one-cycle system-error pulse.

Register bus accesses use the start offset of each register. Write data is aligned to bit 0, and read data comes back combinationally from the offset on the bus. Status, command and the captured fields all return to zero on reset.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and serr_o is low.
- R2: Each event pulse sets its status flag at offset 0xC8 one cycle later. The flag positions are: correctable at bit 0, uncorrectable at bit 1, refresh timeout at bit 8, locked access at bit 9, thermal at bit 11. All other status bits read zero.
- R3: Writing the status register clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When an event arrives in the same cycle as a write of 1 to its flag, the flag ends up set.
- R5: A correctable error that arrives while no error is logged is captured. Offset 0x58 then reads address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. Offset 0x70 bit 0 reads address bit 32. Offset 0x5C reads the syndrome.
- R6: While the correctable flag is set and no uncorrectable error is logged, further correctable errors leave offsets 0x58, 0x5C and 0x70 unchanged.
- R7: An uncorrectable error replaces a captured correctable error's address, channel and syndrome. Both flags then read set.
- R8: While the uncorrectable flag is set, no later error changes the captured fields.
- R9: The command register at offset 0xCA is read/write. Only bits 0, 1, 8, 9 and 11 are stored; every other bit reads zero.
- R10: serr_o is high for exactly the one cycle after an event whose command bit is 1, and stays low for an event whose command bit is 0.
- R11: Writes to offsets 0x58, 0x5C and 0x70 have no effect, and unmapped offsets read zero.
- R12: A correctable error that arrives in the same cycle as a write clearing the correctable flag is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Correctable ECC error pulse |
| ue_i | input | 1 | Uncorrectable ECC error pulse |
| err_addr_i | input | PA_W (33) | Failing physical address |
| err_chan_i | input | 1 | Channel of failing access |
| err_syn_i | input | SYN_W (8) | ECC syndrome |
| rfsh_tmo_i | input | 1 | Refresh timeout pulse |
| lock_acc_i | input | 1 | Locked access to non-DRAM pulse |
| therm_i | input | 1 | Thermal event pulse |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data, aligned to bit 0 |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| serr_o | output | 1 | System-error pulse |

## Verification
The main collision is an event pulse and a software write-1-to-clear of the same status flag in one cycle. The bench drives both in a single cycle, once for a refresh timeout and once for a correctable error. It then reads the status back and expects the flag to be set. In the correctable case it also expects the new address and syndrome in the capture registers. A second collision puts a correctable and an uncorrectable error in the same cycle while an uncorrectable error is already held. The bench expects the capture registers to read unchanged.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam int EV_W   = 16;

  localparam logic [REG_AW-1:0] OFS_ADDR = 8'h58;
  localparam logic [REG_AW-1:0] OFS_SYN  = 8'h5C;
  localparam logic [REG_AW-1:0] OFS_EXT  = 8'h70;
  localparam logic [REG_AW-1:0] OFS_STS  = 8'hC8;
  localparam logic [REG_AW-1:0] OFS_CMD  = 8'hCA;

  localparam int EV_CE  = 0;
  localparam int EV_UE  = 1;
  localparam int EV_RTO = 8;
  localparam int EV_LCK = 9;
  localparam int EV_THM = 11;

  localparam logic [EV_W-1:0] EV_MASK = (EV_W'(1) << EV_CE) | (EV_W'(1) << EV_UE) |
                                        (EV_W'(1) << EV_RTO) | (EV_W'(1) << EV_LCK) |
                                        (EV_W'(1) << EV_THM);

  function automatic logic [EV_W-1:0] pack_events(logic ce, logic ue, logic rto,
                                                  logic lck, logic thm);
    logic [EV_W-1:0] v;
    v = '0;
    v[EV_CE]  = ce;
    v[EV_UE]  = ue;
    v[EV_RTO] = rto;
    v[EV_LCK] = lck;
    v[EV_THM] = thm;
    return v;
  endfunction
endpackage

// File: rtl/ecc_err_sts.sv
module ecc_err_sts #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flag
      logic q;
      // set has priority over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (ev_i[i])  q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign sts_o[i] = q;
    end else begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ecc_err_sig.sv
module ecc_err_sig #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] ev_i,
  output logic [W-1:0] cmd_o,
  output logic         serr_o
);
  logic [W-1:0] cmd_q;
  logic         serr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmd_q <= '0;
    else if (we_i) cmd_q <= wdata_i & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b0;
    else         serr_q <= |(ev_i & cmd_q);
  end

  assign cmd_o  = cmd_q;
  assign serr_o = serr_q;
endmodule

// File: rtl/ecc_err_cap.sv
module ecc_err_cap #(
  parameter int PA_W  = 33,
  parameter int SYN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             ue_i,
  input  logic             ce_flag_i,
  input  logic             ue_flag_i,
  input  logic             ce_clr_i,
  input  logic             ue_clr_i,
  input  logic [PA_W-1:0]  addr_i,
  input  logic             chan_i,
  input  logic [SYN_W-1:0] syn_i,
  output logic [PA_W-1:0]  addr_o,
  output logic             chan_o,
  output logic [SYN_W-1:0] syn_o
);
  logic ce_free, ue_free, load;
  logic [PA_W-1:0]  addr_q;
  logic             chan_q;
  logic [SYN_W-1:0] syn_q;

  // a flag being cleared this cycle frees its log slot
  assign ce_free = !ce_flag_i || ce_clr_i;
  assign ue_free = !ue_flag_i || ue_clr_i;
  assign load    = (ue_i && ue_free) || (ce_i && ce_free && ue_free);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
    end else if (load) begin
      addr_q <= addr_i;
      chan_q <= chan_i;
      syn_q  <= syn_i;
    end
  end

  assign addr_o = addr_q;
  assign chan_o = chan_q;
  assign syn_o  = syn_q;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int PA_W      = 33,
  parameter int SYN_W     = 8,
  parameter int GRAIN_LSB = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ue_i,
  input  logic [PA_W-1:0]   err_addr_i,
  input  logic              err_chan_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic              rfsh_tmo_i,
  input  logic              lock_acc_i,
  input  logic              therm_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              serr_o
);
  localparam int LO_W = 32;
  localparam int HI_W = PA_W - LO_W;

  logic [EV_W-1:0]  ev;
  logic [EV_W-1:0]  sts_clr;
  logic [EV_W-1:0]  sts_q;
  logic [EV_W-1:0]  cmd_q;
  logic             wr_sts, wr_cmd;
  logic [PA_W-1:0]  log_addr_q;
  logic             log_chan_q;
  logic [SYN_W-1:0] log_syn_q;

  assign ev      = pack_events(ce_i, ue_i, rfsh_tmo_i, lock_acc_i, therm_i);
  assign wr_sts  = reg_we_i && (reg_addr_i == OFS_STS);
  assign wr_cmd  = reg_we_i && (reg_addr_i == OFS_CMD);
  assign sts_clr = wr_sts ? reg_wdata_i[EV_W-1:0] : '0;

  ecc_err_sts #(.W(EV_W), .MASK(EV_MASK)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .clr_i  (sts_clr),
    .sts_o  (sts_q)
  );

  ecc_err_sig #(.W(EV_W), .MASK(EV_MASK)) u_sig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_cmd),
    .wdata_i (reg_wdata_i[EV_W-1:0]),
    .ev_i    (ev),
    .cmd_o   (cmd_q),
    .serr_o  (serr_o)
  );

  ecc_err_cap #(.PA_W(PA_W), .SYN_W(SYN_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .ue_i      (ue_i),
    .ce_flag_i (sts_q[EV_CE]),
    .ue_flag_i (sts_q[EV_UE]),
    .ce_clr_i  (sts_clr[EV_CE]),
    .ue_clr_i  (sts_clr[EV_UE]),
    .addr_i    (err_addr_i),
    .chan_i    (err_chan_i),
    .syn_i     (err_syn_i),
    .addr_o    (log_addr_q),
    .chan_o    (log_chan_q),
    .syn_o     (log_syn_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_ADDR: begin
        reg_rdata_o[LO_W-1:GRAIN_LSB] = log_addr_q[LO_W-1:GRAIN_LSB];
        reg_rdata_o[0]                = log_chan_q;
      end
      OFS_EXT:  reg_rdata_o[HI_W-1:0]  = log_addr_q[PA_W-1:LO_W];
      OFS_SYN:  reg_rdata_o[SYN_W-1:0] = log_syn_q;
      OFS_STS:  reg_rdata_o[EV_W-1:0]  = sts_q;
      OFS_CMD:  reg_rdata_o[EV_W-1:0]  = cmd_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
  import ecc_err_log_pkg::*;
#(
  parameter int PA_W  = 33,
  parameter int SYN_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              ue_i,
  input logic              rfsh_tmo_i,
  input logic              lock_acc_i,
  input logic              therm_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [REG_DW-1:0] reg_wdata_i,
  input logic              serr_o,
  input logic [EV_W-1:0]   sts_q,
  input logic [EV_W-1:0]   cmd_q,
  input logic [PA_W-1:0]   log_addr_q,
  input logic              log_chan_q,
  input logic [SYN_W-1:0]  log_syn_q
);
  logic            sw;
  logic [EV_W-1:0] evs;
  assign sw  = reg_we_i && (reg_addr_i == OFS_STS);
  assign evs = pack_events(ce_i, ue_i, rfsh_tmo_i, lock_acc_i, therm_i);

  p_ce_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> sts_q[EV_CE]);
  p_ue_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_i |=> sts_q[EV_UE]);
  p_sts_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q & ~EV_MASK) == '0);
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw && reg_wdata_i[EV_CE] && !ce_i) |=> !sts_q[EV_CE]);
  p_w0_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[EV_THM] && !(sw && reg_wdata_i[EV_THM])) |=> sts_q[EV_THM]);
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_tmo_i && sw && reg_wdata_i[EV_RTO]) |=> sts_q[EV_RTO]);
  p_ce_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[EV_CE] && !ue_i && !(sw && reg_wdata_i[EV_CE]))
      |=> ($stable(log_addr_q) && $stable(log_chan_q) && $stable(log_syn_q)));
  p_ue_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[EV_UE] && !(sw && reg_wdata_i[EV_UE]))
      |=> ($stable(log_addr_q) && $stable(log_chan_q) && $stable(log_syn_q)));
  p_cmd_rsvd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q & ~EV_MASK) == '0);
  p_serr_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evs & cmd_q)) |=> serr_o);
  p_serr_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(evs & cmd_q)) |=> !serr_o);
endmodule

bind ecc_err_log ecc_err_log_chk #(.PA_W(PA_W), .SYN_W(SYN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_i        (ce_i),
  .ue_i        (ue_i),
  .rfsh_tmo_i  (rfsh_tmo_i),
  .lock_acc_i  (lock_acc_i),
  .therm_i     (therm_i),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .serr_o      (serr_o),
  .sts_q       (sts_q),
  .cmd_q       (cmd_q),
  .log_addr_q  (log_addr_q),
  .log_chan_q  (log_chan_q),
  .log_syn_q   (log_syn_q)
);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_i = 0, ue_i = 0, rfsh_tmo_i = 0, lock_acc_i = 0, therm_i = 0;
  logic [32:0] err_addr_i = '0;
  logic        err_chan_i = 0;
  logic [7:0]  err_syn_i = '0;
  logic [7:0]  reg_addr_i = '0;
  logic        reg_we_i = 0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        serr_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic last_serr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecc_err_log dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; serr_o sampled after the capturing edge
  task automatic cyc(logic ce, logic ue, logic rf, logic lk, logic th,
                     logic [32:0] a, logic ch, logic [7:0] syn,
                     logic we, logic [7:0] wa, logic [31:0] wd);
    @(negedge clk_i);
    ce_i = ce; ue_i = ue; rfsh_tmo_i = rf; lock_acc_i = lk; therm_i = th;
    err_addr_i = a; err_chan_i = ch; err_syn_i = syn;
    reg_we_i = we; reg_addr_i = wa; reg_wdata_i = wd;
    @(negedge clk_i);
    last_serr = serr_o;
    ce_i = 0; ue_i = 0; rfsh_tmo_i = 0; lock_acc_i = 0; therm_i = 0; reg_we_i = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(0, 0, 0, 0, 0, '0, 0, '0, 1, a, d);
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 addr", 8'h58, 0);
    rd_chk("R1 syn", 8'h5C, 0);
    rd_chk("R1 ext", 8'h70, 0);
    rd_chk("R1 sts", 8'hC8, 0);
    rd_chk("R1 cmd", 8'hCA, 0);
    chk("R1 serr", {31'b0, serr_o}, 0);
  endtask

  task automatic t_ce_capture;
    cyc(1, 0, 0, 0, 0, 33'h1_2345_67FF, 1, 8'h5A, 0, 0, 0);
    rd_chk("R2 sts ce", 8'hC8, 32'h1);
    rd_chk("R5 addr", 8'h58, 32'h2345_6781);
    rd_chk("R5 ext", 8'h70, 32'h1);
    rd_chk("R5 syn", 8'h5C, 32'h5A);
  endtask

  task automatic t_ce_hold;
    cyc(1, 0, 0, 0, 0, 33'h0_0000_1000, 0, 8'h11, 0, 0, 0);
    rd_chk("R6 addr", 8'h58, 32'h2345_6781);
    rd_chk("R6 ext", 8'h70, 32'h1);
    rd_chk("R6 syn", 8'h5C, 32'h5A);
  endtask

  task automatic t_ue_over;
    cyc(0, 1, 0, 0, 0, 33'h0_ABCD_EF00, 0, 8'hC3, 0, 0, 0);
    rd_chk("R7 addr", 8'h58, 32'hABCD_EF00);
    rd_chk("R7 ext", 8'h70, 32'h0);
    rd_chk("R7 syn", 8'h5C, 32'hC3);
    rd_chk("R7 sts", 8'hC8, 32'h3);
  endtask

  task automatic t_ue_hold;
    cyc(1, 1, 0, 0, 0, 33'h1_1111_1111, 1, 8'h77, 0, 0, 0);
    rd_chk("R8 addr", 8'h58, 32'hABCD_EF00);
    rd_chk("R8 ext", 8'h70, 32'h0);
    rd_chk("R8 syn", 8'h5C, 32'hC3);
  endtask

  task automatic t_w1c;
    wr(8'hC8, 32'h2);
    rd_chk("R3 clear ue keep ce", 8'hC8, 32'h1);
    wr(8'hC8, 32'h1);
    rd_chk("R3 clear ce", 8'hC8, 32'h0);
  endtask

  task automatic t_other_events;
    cyc(0, 0, 1, 0, 0, '0, 0, '0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, '0, 0, '0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, '0, 0, '0, 0, 0, 0);
    rd_chk("R2 sts other", 8'hC8, 32'h0B00);
    wr(8'hC8, 32'h0000_FFFF);
    rd_chk("R3 clear all", 8'hC8, 32'h0);
  endtask

  task automatic t_set_wins;
    cyc(0, 0, 1, 0, 0, '0, 0, '0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, '0, 0, '0, 1, 8'hC8, 32'h0100);
    rd_chk("R4 set wins", 8'hC8, 32'h0100);
    wr(8'hC8, 32'h0100);
    rd_chk("R3 clear rto", 8'hC8, 32'h0);
  endtask

  task automatic t_ce_on_clear;
    cyc(1, 0, 0, 0, 0, 33'h0_0000_0200, 0, 8'h01, 0, 0, 0);
    rd_chk("R5 syn first", 8'h5C, 32'h01);
    cyc(1, 0, 0, 0, 0, 33'h0_0F0F_0F80, 1, 8'h02, 1, 8'hC8, 32'h1);
    rd_chk("R12 sts", 8'hC8, 32'h1);
    rd_chk("R12 addr", 8'h58, 32'h0F0F_0F81);
    rd_chk("R12 syn", 8'h5C, 32'h02);
    wr(8'hC8, 32'h1);
  endtask

  task automatic t_cmd;
    wr(8'hCA, 32'hFFFF_FFFF);
    rd_chk("R9 cmd mask", 8'hCA, 32'h0B03);
    wr(8'hCA, 32'h0);
    rd_chk("R9 cmd zero", 8'hCA, 32'h0);
  endtask

  task automatic t_serr;
    wr(8'hCA, 32'h1);
    cyc(1, 0, 0, 0, 0, '0, 0, '0, 0, 0, 0);
    chk("R10 serr ce", {31'b0, last_serr}, 1);
    @(negedge clk_i);
    chk("R10 serr one cycle", {31'b0, serr_o}, 0);
    cyc(0, 1, 0, 0, 0, '0, 0, '0, 0, 0, 0);
    chk("R10 serr masked", {31'b0, last_serr}, 0);
    wr(8'hCA, 32'h0800);
    cyc(0, 0, 0, 0, 1, '0, 0, '0, 0, 0, 0);
    chk("R10 serr thermal", {31'b0, last_serr}, 1);
    wr(8'hCA, 32'h0);
    wr(8'hC8, 32'hFFFF);
  endtask

  task automatic t_ro;
    rd_chk("R11 pre addr", 8'h58, 32'hABCD_EF00);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFF);
    wr(8'h70, 32'hFF);
    rd_chk("R11 addr ro", 8'h58, 32'hABCD_EF00);
    rd_chk("R11 syn ro", 8'h5C, 32'hC3);
    rd_chk("R11 ext ro", 8'h70, 32'h0);
    rd_chk("R11 unmapped", 8'h60, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ce_capture();
    t_ce_hold();
    t_ue_over();
    t_ue_hold();
    t_w1c();
    t_other_events();
    t_set_wins();
    t_ce_on_clear();
    t_cmd();
    t_serr();
    // restore a UE log for the read-only test
    cyc(0, 1, 0, 0, 0, 33'h0_ABCD_EF00, 0, 8'hC3, 0, 0, 0);
    t_ro();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule